// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits beside a program sequencer and decides, in the same cycle, the address of the next instruction. It supports hardware loops that cost no branch cycles. Each cycle in which `step` is high, the instruction at `pc` is treated as executed. The block returns `next_pc` combinationally. The surrounding sequencer loads `next_pc` into its program counter at the clock edge.

A loop-setup instruction is flagged on `setup_valid` while its own address is on `pc`. Two loop types exist:

- **Single-instruction repeat** (`setup_rpt` = 1). The count field holds N-1, and the instruction right after the setup runs N times.
- **Block loop** (`setup_rpt` = 0). The count field holds the iteration count. The body runs from the instruction after the setup up to and including `setup_end`. Active block loops are kept on a context stack that is up to `DEPTH` levels deep. Each context holds a start address, an end address and a remaining-iteration counter.

The decision is an address compare against the stacked contexts. When an inner loop runs out, its context is dropped, and in the same cycle the next loop out checks its own end address.

A three-state controller tracks the mode:

- `ST_IDLE`: no loop is active.
- `ST_LOOP`: one or more block contexts are stacked.
- `ST_RPT`: a single-instruction repeat is running, possibly inside block loops.

Its transitions are:

- **IDLE→RPT** and **LOOP→RPT**: a repeat setup is accepted.
- **IDLE→LOOP**: a block setup is accepted.
- **LOOP→IDLE**: the last stacked context is popped.
- **RPT→LOOP**: the repeat ends while block contexts remain.
- **RPT→IDLE**: the repeat ends and no block context remains.

Top module: `zol_seq`

## Requirements
- R1: After reset no loop is active. A step at any address gives `next_pc` = `pc`+1, `loop_back` = 0 and `ovf_err` = 0.
- R2: A repeat setup (`setup_rpt`=1) at address P with count field C makes the instruction at P+1 execute C+1 times. `loop_back`=1 and `next_pc`=P+1 on the first C of those steps, then `next_pc`=P+2.
- R3: A block setup (`setup_rpt`=0) at address P with count N≥1 and end E runs the body P+1..E exactly N times, then continues at E+1. At E, while iterations remain, `next_pc`=P+1 and `loop_back`=1.
- R4: A block setup with count 0 skips the body. `next_pc`=E+1 on the setup step, and no context is stored.
- R5: Block loops nest. An outer loop of N iterations around an inner loop of M iterations executes the inner body N×M times.
- R6: When nested loops share an end address, the exhausted inner context is popped and the outer loop-back is decided in that same step. This also holds for several levels at once.
- R7: Up to DEPTH (default 4) block contexts are held. A block setup with nonzero count while DEPTH contexts are stacked is ignored: no context is added, `next_pc`=`pc`+1, and `ovf_err` is high for exactly the one cycle after that step.
- R8: Loop-back adds no cycles. A program executes in exactly as many step cycles as it issues instructions.
- R9: While `step` is low, `loop_back` stays 0 and no loop state changes.
- R10: A repeated instruction placed at the end address of a block loop finishes its repeats first. On its final execution, the block end check applies in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | The instruction at `pc` executes this cycle |
| pc | input | AW | Address of the current instruction |
| setup_valid | input | 1 | The current instruction is a loop setup |
| setup_rpt | input | 1 | 1: single-instruction repeat, 0: block loop |
| setup_count | input | CW | Repeat: N-1; block: iteration count |
| setup_end | input | AW | Last address of a block loop body |
| next_pc | output | AW | Address of the next instruction |
| loop_back | output | 1 | `next_pc` is a loop-back target this cycle |
| ovf_err | output | 1 | One-cycle pulse after a rejected nested setup |

## Verification
The bench runs small programs through a program-counter model and counts how often each address executes. It sweeps repeat counts, block counts and nested count pairs, and compares the counts and the total number of cycles against closed-form products.

Shared end addresses are a key target. A design that pops the inner context but waits a cycle before checking the outer one would leave the outer loop early, or would take an extra cycle. The full-stack case pushes a fifth setup inside four loops that all end together. A design that accepted that push, or that popped only one level per step, would produce an execution count other than 16 at the inner body.

A repeat sitting on a block end tests the order of the two checks. Count-zero setups test the skip path. Step-free gaps test that loop state holds while the sequencer stalls.

// File: rtl/zol_pkg.sv
package zol_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_RPT  = 2'd2
    } zol_state_e;

endpackage

// File: rtl/zol_ctx_stack.sv
module zol_ctx_stack #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [AW-1:0]  push_start,
    input  logic [AW-1:0]  push_end,
    input  logic [CW-1:0]  push_cnt,
    input  logic [DPW-1:0] pop_n,
    input  logic           dec,
    output logic [DPW-1:0] depth,
    output logic [AW-1:0]  ent_start [DEPTH],
    output logic [AW-1:0]  ent_end   [DEPTH],
    output logic [CW-1:0]  ent_cnt   [DEPTH]
);

    logic [DPW-1:0] depth_q;
    logic [DPW-1:0] depth_after;

    // level count left once the popped contexts are gone
    assign depth_after = depth_q - pop_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (push) begin
            depth_q <= depth_q + DPW'(1);
        end else begin
            depth_q <= depth_after;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_level
            logic [AW-1:0] start_q;
            logic [AW-1:0] end_q;
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    start_q <= '0;
                    end_q   <= '0;
                    cnt_q   <= '0;
                end else if (push && depth_q == DPW'(g)) begin
                    start_q <= push_start;
                    end_q   <= push_end;
                    cnt_q   <= push_cnt;
                end else if (dec && depth_after == DPW'(g + 1)) begin
                    cnt_q   <= cnt_q - CW'(1);
                end
            end

            assign ent_start[g] = start_q;
            assign ent_end[g]   = end_q;
            assign ent_cnt[g]   = cnt_q;
        end
    endgenerate

    assign depth = depth_q;

endmodule

// File: rtl/zol_rpt_unit.sv
module zol_rpt_unit #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          dec,
    output logic [AW-1:0] rpt_addr,
    output logic [CW-1:0] rpt_cnt
);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            cnt_q  <= load_cnt;
        end else if (dec) begin
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    assign rpt_addr = addr_q;
    assign rpt_cnt  = cnt_q;

endmodule

// File: rtl/zol_next_pc.sv
module zol_next_pc #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input  logic           step,
    input  logic [AW-1:0]  pc,
    input  logic           setup_valid,
    input  logic           setup_rpt,
    input  logic [CW-1:0]  setup_count,
    input  logic [AW-1:0]  setup_end,
    input  logic           rpt_on,
    input  logic [AW-1:0]  rpt_addr,
    input  logic [CW-1:0]  rpt_cnt,
    input  logic [DPW-1:0] depth,
    input  logic [AW-1:0]  ent_start [DEPTH],
    input  logic [AW-1:0]  ent_end   [DEPTH],
    input  logic [CW-1:0]  ent_cnt   [DEPTH],
    output logic [AW-1:0]  next_pc,
    output logic           loop_back,
    output logic           push,
    output logic [AW-1:0]  push_start,
    output logic [CW-1:0]  push_cnt,
    output logic [DPW-1:0] pop_n,
    output logic           dec,
    output logic           rpt_load,
    output logic           rpt_dec,
    output logic           rpt_done,
    output logic           ovf_req
);

    logic           scan;
    logic [DPW-1:0] pops_v;

    always_comb begin
        next_pc    = pc + AW'(1);
        loop_back  = 1'b0;
        push       = 1'b0;
        push_start = pc + AW'(1);
        push_cnt   = setup_count - CW'(1);
        pop_n      = '0;
        dec        = 1'b0;
        rpt_load   = 1'b0;
        rpt_dec    = 1'b0;
        rpt_done   = 1'b0;
        ovf_req    = 1'b0;
        scan       = 1'b0;
        pops_v     = '0;
        if (step) begin
            if (setup_valid) begin
                if (setup_rpt) begin
                    rpt_load = 1'b1;
                end else if (setup_count == '0) begin
                    next_pc = setup_end + AW'(1);
                end else if (depth == DPW'(DEPTH)) begin
                    ovf_req = 1'b1;
                end else begin
                    push = 1'b1;
                end
            end else begin
                scan = 1'b1;
                // the repeat decision comes before any block end check
                if (rpt_on && pc == rpt_addr) begin
                    if (rpt_cnt != '0) begin
                        next_pc   = pc;
                        loop_back = 1'b1;
                        rpt_dec   = 1'b1;
                        scan      = 1'b0;
                    end else begin
                        rpt_done  = 1'b1;
                    end
                end
                // walk the stack from the innermost level outwards
                for (int k = DEPTH - 1; k >= 0; k--) begin
                    if (scan && DPW'(k) < depth) begin
                        if (ent_end[k] == pc) begin
                            if (ent_cnt[k] != '0) begin
                                next_pc   = ent_start[k];
                                loop_back = 1'b1;
                                dec       = 1'b1;
                                scan      = 1'b0;
                            end else begin
                                pops_v    = pops_v + DPW'(1);
                            end
                        end else begin
                            scan = 1'b0;
                        end
                    end
                end
                pop_n = pops_v;
            end
        end
    end

endmodule

// File: rtl/zol_seq.sv
module zol_seq #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [AW-1:0] pc,
    input  logic          setup_valid,
    input  logic          setup_rpt,
    input  logic [CW-1:0] setup_count,
    input  logic [AW-1:0] setup_end,
    output logic [AW-1:0] next_pc,
    output logic          loop_back,
    output logic          ovf_err
);

    import zol_pkg::*;

    localparam int DPW = $clog2(DEPTH + 1);

    zol_state_e     state_q;
    zol_state_e     state_nx;

    logic [DPW-1:0] stk_depth;
    logic [DPW-1:0] depth_left;
    logic [AW-1:0]  ent_start [DEPTH];
    logic [AW-1:0]  ent_end   [DEPTH];
    logic [CW-1:0]  ent_cnt   [DEPTH];

    logic           push;
    logic [AW-1:0]  push_start;
    logic [CW-1:0]  push_cnt;
    logic [DPW-1:0] pop_n;
    logic           dec;
    logic           rpt_load;
    logic           rpt_dec;
    logic           rpt_done;
    logic           ovf_req;
    logic           rpt_on;
    logic [AW-1:0]  rpt_addr;
    logic [CW-1:0]  rpt_cnt;
    logic           ovf_q;

    assign rpt_on = (state_q == ST_RPT);

    zol_next_pc #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_dec (
        .step        (step),
        .pc          (pc),
        .setup_valid (setup_valid),
        .setup_rpt   (setup_rpt),
        .setup_count (setup_count),
        .setup_end   (setup_end),
        .rpt_on      (rpt_on),
        .rpt_addr    (rpt_addr),
        .rpt_cnt     (rpt_cnt),
        .depth       (stk_depth),
        .ent_start   (ent_start),
        .ent_end     (ent_end),
        .ent_cnt     (ent_cnt),
        .next_pc     (next_pc),
        .loop_back   (loop_back),
        .push        (push),
        .push_start  (push_start),
        .push_cnt    (push_cnt),
        .pop_n       (pop_n),
        .dec         (dec),
        .rpt_load    (rpt_load),
        .rpt_dec     (rpt_dec),
        .rpt_done    (rpt_done),
        .ovf_req     (ovf_req)
    );

    zol_ctx_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_start (push_start),
        .push_end   (setup_end),
        .push_cnt   (push_cnt),
        .pop_n      (pop_n),
        .dec        (dec),
        .depth      (stk_depth),
        .ent_start  (ent_start),
        .ent_end    (ent_end),
        .ent_cnt    (ent_cnt)
    );

    zol_rpt_unit #(.AW(AW), .CW(CW)) u_rpt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rpt_load),
        .load_addr (pc + AW'(1)),
        .load_cnt  (setup_count),
        .dec       (rpt_dec),
        .rpt_addr  (rpt_addr),
        .rpt_cnt   (rpt_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx   = state_q;
        depth_left = stk_depth - pop_n;
        unique case (state_q)
            ST_IDLE: begin
                if (rpt_load) begin
                    state_nx = ST_RPT;
                end else if (push) begin
                    state_nx = ST_LOOP;
                end
            end
            ST_LOOP: begin
                if (rpt_load) begin
                    state_nx = ST_RPT;
                end else if (pop_n != '0 && depth_left == '0) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_RPT: begin
                if (rpt_done) begin
                    state_nx = (depth_left != '0) ? ST_LOOP : ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_req;
        end
    end

    assign ovf_err = ovf_q;

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 4,
    localparam int DPW  = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step,
    input logic                setup_valid,
    input logic                setup_rpt,
    input logic [CW-1:0]       setup_count,
    input logic [AW-1:0]       setup_end,
    input logic [AW-1:0]       next_pc,
    input logic                loop_back,
    input logic                ovf_err,
    input logic [DPW-1:0]      depth,
    input zol_pkg::zol_state_e state
);

    import zol_pkg::*;

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DPW'(DEPTH));

    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $past(step && setup_valid && !setup_rpt &&
                          setup_count != '0 && depth == DPW'(DEPTH)));

    p_ovf_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> depth == $past(depth));

    p_zero_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && setup_valid && !setup_rpt && setup_count == '0)
            |-> next_pc == setup_end + AW'(1));

    p_zero_nopush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && setup_valid && !setup_rpt && setup_count == '0)
            |=> depth == $past(depth));

    p_quiet_lb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> !loop_back);

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(depth) && $stable(state)));

    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> depth == '0);

    p_loop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOOP |-> depth != '0);

    p_push_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        depth > $past(depth) |-> depth == $past(depth) + DPW'(1));

endmodule

bind zol_seq zol_seq_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .setup_valid (setup_valid),
    .setup_rpt   (setup_rpt),
    .setup_count (setup_count),
    .setup_end   (setup_end),
    .next_pc     (next_pc),
    .loop_back   (loop_back),
    .ovf_err     (ovf_err),
    .depth       (stk_depth),
    .state       (state_q)
);

// File: tb/sim_zol_seq.sv
module sim_zol_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 16;
    localparam int CW    = 16;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          setup_valid = 1'b0;
    logic          setup_rpt = 1'b0;
    logic [CW-1:0] setup_count = '0;
    logic [AW-1:0] setup_end = '0;
    logic [AW-1:0] next_pc;
    logic          loop_back;
    logic          ovf_err;

    int n_chk  = 0;
    int n_fail = 0;
    int exec_n [64];
    bit pv [64];
    bit pr [64];
    int pcnt [64];
    int pend [64];
    int ovf_seen;
    int cyc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    zol_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .pc          (pc),
        .setup_valid (setup_valid),
        .setup_rpt   (setup_rpt),
        .setup_count (setup_count),
        .setup_end   (setup_end),
        .next_pc     (next_pc),
        .loop_back   (loop_back),
        .ovf_err     (ovf_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin
            pv[i] = 1'b0; pr[i] = 1'b0; pcnt[i] = 0; pend[i] = 0;
        end
    endtask

    task automatic put_setup(input int at, input bit is_rpt, input int cnt, input int e);
        pv[at] = 1'b1; pr[at] = is_rpt; pcnt[at] = cnt; pend[at] = e;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step = 1'b0; setup_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_prog(input int stop_pc, input bit gaps);
        int cur;
        cur = 0; cyc = 0; ovf_seen = 0;
        for (int i = 0; i < 64; i++) exec_n[i] = 0;
        while (cur != stop_pc && cyc < 3000) begin
            @(negedge clk);
            if (gaps) begin
                step = 1'b0; setup_valid = 1'b0; pc = AW'(cur);
                #1;
                chk(loop_back == 1'b0, "R9 loop_back while stalled", int'(loop_back), 0);
                @(negedge clk);
            end
            step        = 1'b1;
            pc          = AW'(cur);
            setup_valid = pv[cur % 64];
            setup_rpt   = pr[cur % 64];
            setup_count = CW'(pcnt[cur % 64]);
            setup_end   = AW'(pend[cur % 64]);
            #1;
            exec_n[cur % 64]++;
            cyc++;
            cur = int'(next_pc);
            @(posedge clk);
            #1;
            if (ovf_err) ovf_seen++;
        end
        @(negedge clk);
        step = 1'b0; setup_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        // R1: state after reset
        do_reset();
        step = 1'b1; pc = AW'(7); setup_valid = 1'b0;
        #1;
        chk(next_pc == AW'(8), "R1 next_pc after reset", int'(next_pc), 8);
        chk(loop_back == 1'b0, "R1 loop_back after reset", int'(loop_back), 0);
        chk(ovf_err == 1'b0, "R1 ovf_err after reset", int'(ovf_err), 0);
        @(posedge clk);
        @(negedge clk);
        step = 1'b0;

        // R2 / R8: single-instruction repeat sweep
        for (int c = 0; c <= 5; c++) begin
            do_reset(); clear_prog();
            put_setup(2, 1'b1, c, 0);
            run_prog(10, 1'b0);
            chk(exec_n[3] == c + 1, "R2 repeated instruction count", exec_n[3], c + 1);
            chk(exec_n[4] == 1, "R2 instruction after repeat", exec_n[4], 1);
            chk(cyc == 10 + c, "R8 repeat cycle count", cyc, 10 + c);
        end

        // R3 / R4 / R8: block loop sweep including zero count
        for (int n = 0; n <= 5; n++) begin
            do_reset(); clear_prog();
            put_setup(2, 1'b0, n, 5);
            run_prog(10, 1'b0);
            if (n == 0) begin
                chk(exec_n[3] == 0, "R4 zero count skips body", exec_n[3], 0);
            end else begin
                chk(exec_n[3] == n, "R3 body iterations", exec_n[3], n);
                chk(exec_n[5] == n, "R3 end instruction iterations", exec_n[5], n);
            end
            chk(exec_n[6] == 1, "R3 fall through after end", exec_n[6], 1);
            chk(cyc == 7 + 3 * n, "R8 block cycle count", cyc, 7 + 3 * n);
        end

        // R5: nested loops with distinct ends
        for (int n = 1; n <= 3; n++) begin
            for (int m = 1; m <= 3; m++) begin
                do_reset(); clear_prog();
                put_setup(1, 1'b0, n, 8);
                put_setup(3, 1'b0, m, 6);
                run_prog(10, 1'b0);
                chk(exec_n[4] == n * m, "R5 inner body count", exec_n[4], n * m);
                chk(exec_n[8] == n, "R5 outer tail count", exec_n[8], n);
                chk(cyc == 3 + n * (4 + 3 * m), "R8 nested cycle count", cyc, 3 + n * (4 + 3 * m));
            end
        end

        // R6: nested loops sharing one end address
        for (int n = 1; n <= 3; n++) begin
            for (int m = 1; m <= 3; m++) begin
                do_reset(); clear_prog();
                put_setup(1, 1'b0, n, 6);
                put_setup(3, 1'b0, m, 6);
                run_prog(9, 1'b0);
                chk(exec_n[6] == n * m, "R6 shared end count", exec_n[6], n * m);
                chk(exec_n[2] == n, "R6 outer head count", exec_n[2], n);
                chk(cyc == 4 + n * (2 + 3 * m), "R6 shared end cycle count", cyc, 4 + n * (2 + 3 * m));
            end
        end

        // R10: repeat on the last instruction of a block
        for (int n = 1; n <= 3; n++) begin
            for (int c = 0; c <= 2; c++) begin
                do_reset(); clear_prog();
                put_setup(1, 1'b0, n, 4);
                put_setup(3, 1'b1, c, 0);
                run_prog(8, 1'b0);
                chk(exec_n[4] == n * (c + 1), "R10 repeat at block end", exec_n[4], n * (c + 1));
                chk(exec_n[5] == 1, "R10 exit after block", exec_n[5], 1);
                chk(cyc == 5 + n * (3 + c), "R10 cycle count", cyc, 5 + n * (3 + c));
            end
        end

        // R7 / R6: four full levels ending together, fifth setup rejected
        do_reset(); clear_prog();
        put_setup(1, 1'b0, 2, 12);
        put_setup(2, 1'b0, 2, 12);
        put_setup(3, 1'b0, 2, 12);
        put_setup(4, 1'b0, 2, 12);
        put_setup(5, 1'b0, 3, 12);
        run_prog(13, 1'b0);
        chk(exec_n[6] == 16, "R7 fifth level ignored", exec_n[6], 16);
        chk(ovf_seen == 16, "R7 overflow pulses", ovf_seen, 16);
        chk(exec_n[2] == 2, "R6 multi-level pop outer count", exec_n[2], 2);
        chk(cyc == 144, "R8 deep nest cycle count", cyc, 144);

        // R9: stalls between steps leave the loop intact
        do_reset(); clear_prog();
        put_setup(2, 1'b0, 3, 5);
        run_prog(10, 1'b1);
        chk(exec_n[3] == 3, "R9 iterations with stalls", exec_n[3], 3);
        chk(cyc == 16, "R9 steps with stalls", cyc, 16);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule